// File: doc/BRIEF.md
# RAM-Based Transposed FIR Engine

This block is a long FIR filter in transposed form. It keeps one running partial sum per tap in a block RAM, not in a chain of registers. A single shared multiply-accumulate datapath serves every tap. When a sample is accepted, a sequencer visits every tap slot once, working from the highest slot down to slot 0. At each slot it reads the stored partial sum and adds to it the product of the new sample and that slot's coefficient. It then writes the result one slot higher. The sum formed at the top slot does not go back to the RAM. It leaves the block as the filter result, marked by a one-cycle valid pulse.

Coefficients live in their own RAM, and a plain write port loads them. The accumulator RAM has one cycle of read latency. The write-back address therefore trails the read address through a one-stage pipeline. A pass over N taps keeps the block busy for N+1 cycles. Any sample offered during that time is dropped, and the busy output reports this.

The sequencer has four states. CLEAR is entered on reset: it zeroes one accumulator slot per cycle and moves to IDLE after the last slot (clear-done). IDLE moves to RUN when a sample is offered (accept). RUN issues one read per cycle, counting the slot down, and moves to DRAIN after slot 0 (last-read). DRAIN spends one cycle retiring the final write-back and returns to IDLE (drain-done).

Top module: `tfir_ram_engine`

## Requirements
- R1: While reset is high, `busy` is 1 and `res_valid` is 0. After reset falls, `busy` stays 1 for exactly NTAPS cycles while every partial sum is set to zero, and then drops to 0.
- R2: Coefficient address a weights the sample accepted a samples earlier. With fixed coefficients, the result for accepted sample n is the sum over a = 0..NTAPS-1 of C[a]·x[n−a]. Samples from before the first one accepted after reset count as zero.
- R3: A high `coef_we` at a clock edge stores `coef_data` at `coef_addr`. The stored value is used by every pass that starts after that edge.
- R4: Samples and coefficients are two's complement. The product is sign-extended to the accumulator width (20 bits by default). Every sum wraps modulo 2^20 and never saturates.
- R5: `res_valid` is a pulse exactly one cycle wide. It is visible in the cycle after the second rising edge that follows the accepting edge, and `res_data` carries the result in that same cycle.
- R6: A sample is accepted only when `busy` is 0. `busy` then stays 1 for NTAPS+1 cycles. A sample offered while `busy` is 1 is dropped: it produces no pulse and has no effect on any later result.
- R7: Each partial sum keeps the products formed with the coefficients that were current when it was updated. A coefficient rewritten between samples affects only the passes that run after the write.
- R8: A sample accepted at the first idle edge after a pass sees every write-back of that pass. The write-back never targets the slot being read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_data | input | SAMPLE_W | Signed sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | SLOT_W | Coefficient address (delay in samples) |
| coef_data | input | COEF_W | Signed coefficient |
| busy | output | 1 | Pass or clear in progress; offered samples are dropped |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | ACC_W | Signed filter result |

## Verification
Two events can fall in the same cycle: a new sample arriving, and the closing of the previous pass in DRAIN, when its last write-back lands. The bench provokes this by holding `smp_valid` high across many passes. It also sends samples at the minimum spacing, so that each one arrives in the first idle cycle. A behavioural model of the transposed recurrence, kept in plain integer arrays, predicts `busy`, `res_valid` and `res_data` on every clock. A sample dropped in DRAIN therefore shows up as a wrong pulse count. A sample accepted early, or one that reads a stale partial sum, shows up as a wrong result.

// File: rtl/tfir_pkg.sv
package tfir_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_RUN,
        ST_DRAIN
    } seq_state_t;
endpackage

// File: rtl/tfir_slot_ram.sv
module tfir_slot_ram #(
    parameter int WIDTH = 20,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // One write port, one registered read port (read returns the old word)
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tfir_mac.sv
module tfir_mac #(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 10,
    parameter int ACC_W    = 20
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [COEF_W-1:0]   coef,
    input  logic        [ACC_W-1:0]    addend,
    output logic        [ACC_W-1:0]    sum
);
    localparam int PROD_W = SAMPLE_W + COEF_W;

    logic signed [PROD_W-1:0] prod;
    logic        [ACC_W-1:0]  prod_ext;

    assign prod = sample * coef;

    generate
        if (PROD_W < ACC_W) begin : g_extend
            assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
        end else begin : g_wrap
            assign prod_ext = prod[ACC_W-1:0];
        end
    endgenerate

    // Modular add: overflow wraps at ACC_W bits
    assign sum = addend + prod_ext;
endmodule

// File: rtl/tfir_seq.sv
module tfir_seq
    import tfir_pkg::*;
#(
    parameter int NTAPS  = 16,
    parameter int SLOT_W = $clog2(NTAPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    output logic [SLOT_W-1:0] slot,
    output logic              busy,
    output logic              accept,
    output logic              rd_en,
    output logic              clr_we
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NTAPS - 1);

    seq_state_t        state, state_nxt;
    logic [SLOT_W-1:0] slot_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CLEAR;
            slot  <= '0;
        end else begin
            state <= state_nxt;
            slot  <= slot_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        slot_nxt  = slot;
        unique case (state)
            ST_CLEAR: begin
                if (slot == LAST) begin
                    state_nxt = ST_IDLE;
                    slot_nxt  = '0;
                end else begin
                    slot_nxt = slot + SLOT_W'(1);
                end
            end
            ST_IDLE: begin
                if (smp_valid) begin
                    state_nxt = ST_RUN;
                    slot_nxt  = LAST;
                end
            end
            ST_RUN: begin
                if (slot == '0) begin
                    state_nxt = ST_DRAIN;
                end else begin
                    slot_nxt = slot - SLOT_W'(1);
                end
            end
            ST_DRAIN: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy   = (state != ST_IDLE);
        accept = (state == ST_IDLE) && smp_valid;
        rd_en  = (state == ST_RUN);
        clr_we = (state == ST_CLEAR);
    end

    AST_RUN_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && $past(state) == ST_IDLE) |-> $past(smp_valid)); // R6
    AST_SLOT_DESCENDS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (slot == $past(slot) - SLOT_W'(1))); // R8
    AST_IDLE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state) == ST_CLEAR) |-> ($past(slot) == LAST)); // R1
endmodule

// File: rtl/tfir_ram_engine.sv
module tfir_ram_engine #(
    parameter int NTAPS    = 16,
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 10,
    parameter int ACC_W    = 20,
    parameter int SLOT_W   = $clog2(NTAPS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                coef_we,
    input  logic [SLOT_W-1:0]   coef_addr,
    input  logic [COEF_W-1:0]   coef_data,
    output logic                busy,
    output logic                res_valid,
    output logic [ACC_W-1:0]    res_data
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NTAPS - 1);

    logic [SLOT_W-1:0]   slot;
    logic                accept, rd_en, clr_we;
    logic [SAMPLE_W-1:0] x_q;
    logic                p_valid;
    logic [SLOT_W-1:0]   p_slot;
    logic [ACC_W-1:0]    acc_rdata, acc_wdata, addend, sum;
    logic [SLOT_W-1:0]   acc_waddr;
    logic                acc_we;
    logic [COEF_W-1:0]   coef_rdata;

    tfir_seq #(.NTAPS(NTAPS), .SLOT_W(SLOT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .slot      (slot),
        .busy      (busy),
        .accept    (accept),
        .rd_en     (rd_en),
        .clr_we    (clr_we)
    );

    // Sample latch and one-stage read pipeline (covers the RAM read latency)
    always_ff @(posedge clk) begin
        if (rst) begin
            x_q     <= '0;
            p_valid <= 1'b0;
            p_slot  <= '0;
        end else begin
            if (accept) begin
                x_q <= smp_data;
            end
            p_valid <= rd_en;
            p_slot  <= slot;
        end
    end

    // Write-back lands one slot above the slot that was read; the top slot leaves as the result
    assign acc_we    = clr_we || (p_valid && (p_slot != LAST));
    assign acc_waddr = clr_we ? slot : (p_slot + SLOT_W'(1));
    assign acc_wdata = clr_we ? '0 : sum;
    assign addend    = (p_slot == '0) ? '0 : acc_rdata;

    tfir_slot_ram #(.WIDTH(ACC_W), .DEPTH(NTAPS), .AW(SLOT_W)) u_acc_ram (
        .clk   (clk),
        .we    (acc_we),
        .waddr (acc_waddr),
        .wdata (acc_wdata),
        .raddr (slot),
        .rdata (acc_rdata)
    );

    tfir_slot_ram #(.WIDTH(COEF_W), .DEPTH(NTAPS), .AW(SLOT_W)) u_coef_ram (
        .clk   (clk),
        .we    (coef_we),
        .waddr (coef_addr),
        .wdata (coef_data),
        .raddr (LAST - slot),
        .rdata (coef_rdata)
    );

    tfir_mac #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
        .sample (x_q),
        .coef   (coef_rdata),
        .addend (addend),
        .sum    (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= p_valid && (p_slot == LAST);
            if (p_valid && (p_slot == LAST)) begin
                res_data <= sum;
            end
        end
    end

    AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R5
    AST_RES_WITHIN_PASS: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> busy); // R5
    AST_DROPPED_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && busy) |=> $stable(x_q)); // R6
    AST_WB_NOT_READ: assert property (@(posedge clk) disable iff (rst)
        (acc_we && rd_en) |-> (acc_waddr != slot)); // R8
endmodule

// File: tb/tfir_ram_engine_test.sv
`timescale 1ns/1ps
module tfir_ram_engine_test;
    localparam int N  = 16;
    localparam int SW = 8;
    localparam int CW = 10;
    localparam int AW = 20;
    localparam int LW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          coef_we = 1'b0;
    logic [LW-1:0] coef_addr = '0;
    logic [CW-1:0] coef_data = '0;
    logic          busy, res_valid;
    logic [AW-1:0] res_data;

    always #2.5 clk = ~clk;

    tfir_ram_engine #(.NTAPS(N), .SAMPLE_W(SW), .COEF_W(CW), .ACC_W(AW)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
        .busy(busy), .res_valid(res_valid), .res_data(res_data)
    );

    int    vectors = 0, miscompares = 0;
    bit    done = 0;
    string phase_tag = "R2 result";

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint wrap(input longint v);
        longint m;
        m = v & ((longint'(1) << AW) - 1);
        if (m >= (longint'(1) << (AW - 1))) m = m - (longint'(1) << AW);
        return m;
    endfunction

    // Behavioural reference of the transposed recurrence
    longint psum [N];
    longint coef_m [N];
    int     busy_left = N;
    bit     in_clear = 1, s0 = 0, s1 = 0, exp_valid = 0;
    longint s0d = 0, s1d = 0, exp_data = 0;

    always @(posedge clk) begin
        if (rst) begin
            busy_left = N; in_clear = 1; s0 = 0; s1 = 0; exp_valid = 0;
            for (int i = 0; i < N; i++) psum[i] = 0;
        end else begin
            exp_valid = s1;
            if (s1) exp_data = s1d;
            s1 = s0; s1d = s0d; s0 = 0;
            if (coef_we) coef_m[coef_addr] = longint'($signed(coef_data));
            if (busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) in_clear = 0;
            end else if (smp_valid) begin
                longint x, v;
                x = longint'($signed(smp_data));
                for (int i = N - 1; i >= 0; i--) begin
                    v = wrap(((i == 0) ? 0 : psum[i]) + coef_m[N - 1 - i] * x);
                    if (i == N - 1) s0d = v;
                    else psum[i + 1] = v;
                end
                s0 = 1;
                busy_left = N + 1;
            end
        end
    end

    // Per-cycle comparison and capture, away from the active edge
    longint got [$];
    bit     cap_en = 0;
    int     pulse_cnt = 0;
    longint last_res = 0;

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                chk(busy === 1'b1 && res_valid === 1'b0, "R1 reset state", {busy, res_valid}, 2);
            end else begin
                chk(busy === (busy_left > 0), in_clear ? "R1 busy during clear" : "R6 busy",
                    busy, (busy_left > 0));
                chk(res_valid === exp_valid, "R5 valid pulse", res_valid, exp_valid);
                if (res_valid && exp_valid)
                    chk(longint'($signed(res_data)) == exp_data, phase_tag,
                        longint'($signed(res_data)), exp_data);
                if (res_valid) begin
                    pulse_cnt++;
                    last_res = longint'($signed(res_data));
                    if (cap_en) got.push_back(longint'($signed(res_data)));
                end
            end
        end
    end

    longint coef_b [N];

    task automatic wr_coef(input int a, input longint c);
        @(posedge clk); #1;
        coef_we = 1; coef_addr = LW'(a); coef_data = CW'(c);
        coef_b[a] = c;
        @(posedge clk); #1;
        coef_we = 0;
    endtask

    task automatic send(input longint x);
        @(posedge clk); #1;
        smp_valid = 1; smp_data = SW'(x);
        @(posedge clk); #1;
        smp_valid = 0;
        repeat (N) @(posedge clk);
    endtask

    task automatic flush();
        for (int k = 0; k < N; k++) send(0);
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!done) begin
            repeat (199000) @(posedge clk);
            if (!done) begin
                done = 1;
                miscompares++;
                $display("FAIL watchdog expired actual=0 expected=1");
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] lfsr;
        longint old_c [N];
        repeat (4) @(posedge clk);
        #1 rst = 0;
        repeat (N + 2) @(posedge clk);

        // R3: load coefficients, mixed signs
        for (int a = 0; a < N; a++) wr_coef(a, ((a * 97 + 13) % 1024) - 512);

        // R2: impulse response reproduces coefficients in address order
        phase_tag = "R2 impulse result";
        flush();
        got.delete(); cap_en = 1;
        send(1);
        for (int k = 1; k < N; k++) send(0);
        cap_en = 0;
        chk(got.size() == N, "R2 impulse output count", got.size(), N);
        for (int k = 0; k < N && k < got.size(); k++)
            chk(got[k] == coef_b[k], "R2 impulse tap", got[k], coef_b[k]);

        // R2/R4: pseudo-random signed samples against the model
        phase_tag = "R4 random samples";
        lfsr = 16'hACE1;
        for (int k = 0; k < 3 * N; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(longint'($signed(lfsr[7:0])));
        end

        // R7: coefficients rewritten while an impulse is in flight
        phase_tag = "R7 in-flight coefficient change";
        flush();
        for (int a = 0; a < N; a++) old_c[a] = coef_b[a];
        got.delete(); cap_en = 1;
        send(1);
        for (int a = 0; a < N; a++) wr_coef(a, -coef_b[a] / 2 + 3);
        for (int k = 1; k < N; k++) send(0);
        cap_en = 0;
        for (int k = 0; k < N && k < got.size(); k++)
            chk(got[k] == old_c[k], "R7 old products kept", got[k], old_c[k]);

        // R3: a single rewritten coefficient shows up in the next impulse
        phase_tag = "R3 rewritten coefficient";
        wr_coef(5, -77);
        flush();
        got.delete(); cap_en = 1;
        send(1);
        for (int k = 1; k < N; k++) send(0);
        cap_en = 0;
        if (got.size() > 5) chk(got[5] == -77, "R3 rewritten tap", got[5], -77);
        if (got.size() > 4) chk(got[4] == coef_b[4], "R3 untouched tap", got[4], coef_b[4]);

        // R4: overflow wraps at the accumulator width
        phase_tag = "R4 wrap";
        for (int a = 0; a < N; a++) wr_coef(a, 511);
        for (int k = 0; k < N; k++) send(127);
        chk(last_res == wrap(longint'(N) * 127 * 511), "R4 wrapped sum",
            last_res, wrap(longint'(N) * 127 * 511));
        for (int a = 0; a < N; a++) wr_coef(a, -512);
        for (int k = 0; k < N; k++) send(-128);
        chk(last_res == wrap(longint'(N) * 128 * 512), "R4 wrapped negative product sum",
            last_res, wrap(longint'(N) * 128 * 512));

        // R6/R8: valid held high; samples in RUN/DRAIN dropped, first idle accepted
        phase_tag = "R8 back-to-back result";
        for (int a = 0; a < N; a++) wr_coef(a, (a * 29) % 200 - 100);
        repeat (2) @(posedge clk);
        #1 pulse_cnt = 0;
        smp_valid = 1;
        for (int c = 0; c <= 4 * (N + 2); c++) begin
            smp_data = SW'(c * 7 - 60);
            @(posedge clk); #1;
        end
        smp_valid = 0;
        repeat (N + 4) @(posedge clk);
        #1 chk(pulse_cnt == 5, "R6 accepted samples under constant valid", pulse_cnt, 5);

        repeat (4) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule